// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Block

This block is a small real-time-clock register file that software reaches through two byte-wide ports. A write to the select port latches an 8-bit register index. A read or write of the data port then reaches the register that index names. The time registers keep binary, 24-hour values. The control registers report and check one fixed operating mode. A periodic interrupt and a seconds prescaler are both driven by an external 1024 Hz tick strobe.

Register A reports a fixed rate word and an update-in-progress flag. That flag flips on every read of register A, so software polling it always sees it change. Register B always reads back the supported mode. A write to B is checked against that mode, and its periodic-enable bit starts or stops the interrupt. A write that asks for something the block does not support raises a one-cycle error pulse and changes nothing. Only seconds and minutes advance on their own; carries stop at the minute wrap.

Top module: `rtc_regfile`

## Requirements
- R1: After reset: the select port reads 0x00, every time register reads 0x00 except day-of-week which reads 0x01, register A reads 0x26, err_o and pirq_o are low, and the periodic interrupt is enabled.
- R2: A write with sel_i=0 latches wdata_i as the index, and a read with sel_i=0 returns the index. With sel_i=1, data writes store and data reads return the full byte at indices 0x00 (seconds), 0x02 (minutes), 0x04 (hours), 0x07 (day of month), 0x08 (month) and 0x09 (year).
- R3: Day of week (index 0x06) is kept zero-based: a written value v is stored as v-1 and a read returns the stored value plus 1, so values 1 to 7 read back unchanged.
- R4: A data read of index 0x0A returns 0x26 with the update-in-progress flag in bit 7, and each such read inverts that flag for the next read.
- R5: A data write of 0x26 to index 0x0A is accepted silently; any other value gives an err_o pulse in the cycle after the write.
- R6: A data read of index 0x0B always returns 0x46.
- R7: A data write v to index 0x0B is legal when (v AND 0xB7) equals 0x06; otherwise err_o pulses in the next cycle and the periodic enable keeps its value.
- R8: A legal write to index 0x0B sets the periodic enable to bit 6 of the written value.
- R9: While the periodic enable is set, pirq_o is high for exactly the one cycle after each cycle in which tick_i is high; while it is clear, pirq_o stays low.
- R10: Data writes to index 0x0C or 0x0D give an err_o pulse; data reads of them return 0x00.
- R11: Seconds advance by one on every 1024th tick; a data write to the seconds register restarts the tick count from zero.
- R12: When seconds step from 59 they go to 0 and minutes advance by one. Minutes step from 59 to 0 with no change to the hours register.
- R13: Data writes to indices 0x01, 0x03, 0x05 and 0x0E and above are ignored with no err_o pulse, and data reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | 0 selects the index port, 1 selects the data port |
| rd_i | input | 1 | Read strobe for the selected port |
| wr_i | input | 1 | Write strobe for the selected port |
| wdata_i | input | 8 | Write data |
| tick_i | input | 1 | 1024 Hz tick strobe, one cycle wide |
| rdata_o | output | 8 | Read data for the selected port, combinational |
| pirq_o | output | 1 | Periodic interrupt pulse |
| err_o | output | 1 | Illegal control write pulse |

## Verification
All 256 byte values are written to registers A and B. The error pulse must match the arithmetic legality rule exactly, and the tick that follows each B write must show whether the periodic enable took the new bit-6 value or kept the old one; this separates masking mistakes from enable-update mistakes. The plain time registers each get a full 0 to 255 write/read sweep, and day of week gets its 1 to 7 range, which exposes any offset or aliasing between indices. Tick runs of 1023 and 1024 bracket the seconds boundary. A run started from 59:59 checks the carry into minutes and that the carry stops before hours. A seconds write made halfway through a count shows that the prescaler restarts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] IDX_SEC  = 8'h00;
  localparam logic [7:0] IDX_MIN  = 8'h02;
  localparam logic [7:0] IDX_HOUR = 8'h04;
  localparam logic [7:0] IDX_DOW  = 8'h06;
  localparam logic [7:0] IDX_DOM  = 8'h07;
  localparam logic [7:0] IDX_MON  = 8'h08;
  localparam logic [7:0] IDX_YEAR = 8'h09;
  localparam logic [7:0] IDX_CA   = 8'h0A;
  localparam logic [7:0] IDX_CB   = 8'h0B;
  localparam logic [7:0] IDX_CC   = 8'h0C;
  localparam logic [7:0] IDX_CD   = 8'h0D;

  localparam logic [7:0] CA_RATE  = 8'h26;  // 32.768 kHz base | 1024 Hz rate
  localparam logic [7:0] CB_MODE  = 8'h46;  // periodic en | binary | 24 h
  localparam logic [7:0] CB_PIE   = 8'h40;
  localparam logic [7:0] CB_SQW   = 8'h08;
  localparam logic [7:0] CB_REQ   = 8'h06;
  localparam int unsigned CB_PIE_BIT = 6;

  localparam logic [7:0] MAX_SEC = 8'd59;
  localparam logic [7:0] MAX_MIN = 8'd59;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dow;   // zero-based
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic step_o
);
  generate
    if (TICKS_PER_SEC > 1) begin : g_cnt
      localparam int unsigned CW = $clog2(TICKS_PER_SEC);
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
      logic [CW-1:0] cnt_q;

      assign step_o = tick_i && (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (clr_i)   cnt_q <= '0;
        else if (tick_i)  cnt_q <= step_o ? '0 : cnt_q + 1'b1;
      end
    end else begin : g_pass
      logic unused_pass;
      assign unused_pass = ^{clk_i, rst_ni, clr_i};
      assign step_o = tick_i;
    end
  endgenerate
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  input  logic       step_i,
  output logic       sec_wr_o,
  output rtc_time_t  time_o
);
  rtc_time_t t_q, t_d;

  assign sec_wr_o = wr_i && (idx_i == IDX_SEC);

  always_comb begin
    t_d = t_q;
    // a seconds write restarts the count and wins over a step
    if (step_i && !sec_wr_o) begin
      if (t_q.sec >= MAX_SEC) begin
        t_d.sec = '0;
        t_d.min = (t_q.min >= MAX_MIN) ? 8'd0 : t_q.min + 8'd1;
      end else begin
        t_d.sec = t_q.sec + 8'd1;
      end
    end
    if (wr_i) begin
      unique case (idx_i)
        IDX_SEC:  t_d.sec  = wdata_i;
        IDX_MIN:  t_d.min  = wdata_i;
        IDX_HOUR: t_d.hour = wdata_i;
        IDX_DOW:  t_d.dow  = wdata_i - 8'd1;
        IDX_DOM:  t_d.dom  = wdata_i;
        IDX_MON:  t_d.mon  = wdata_i;
        IDX_YEAR: t_d.year = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t_q <= '0;
    else         t_q <= t_d;
  end

  assign time_o = t_q;
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  input  logic       tick_i,
  output logic       uip_o,
  output logic       per_en_o,
  output logic       err_o,
  output logic       pirq_o
);
  logic hit_a, hit_b, hit_cd;
  logic bad_a, bad_b, bad;
  logic b_ok;
  logic uip_q, per_en_q, err_q, pirq_q;

  assign hit_a  = idx_i == IDX_CA;
  assign hit_b  = idx_i == IDX_CB;
  assign hit_cd = (idx_i == IDX_CC) || (idx_i == IDX_CD);

  assign bad_a = wdata_i != CA_RATE;
  assign bad_b = (wdata_i & ~(CB_PIE | CB_SQW)) != CB_REQ;
  assign bad   = wr_i && ((hit_a && bad_a) || (hit_b && bad_b) || hit_cd);
  assign b_ok  = wr_i && hit_b && !bad_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uip_q    <= 1'b0;
      per_en_q <= 1'b1;
      err_q    <= 1'b0;
      pirq_q   <= 1'b0;
    end else begin
      if (rd_i && hit_a) uip_q <= ~uip_q;
      if (b_ok) per_en_q <= wdata_i[CB_PIE_BIT];
      err_q  <= bad;
      pirq_q <= tick_i && per_en_q;
    end
  end

  assign uip_o    = uip_q;
  assign per_en_o = per_en_q;
  assign err_o    = err_q;
  assign pirq_o   = pirq_q;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       tick_i,
  output logic [7:0] rdata_o,
  output logic       pirq_o,
  output logic       err_o
);
  logic [7:0] idx_q;
  logic       data_wr, data_rd;
  logic       sec_step, sec_wr;
  logic       uip, per_en;
  rtc_time_t  tm_q;
  logic [7:0] data_mux;

  assign data_wr = wr_i && sel_i;
  assign data_rd = rd_i && sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idx_q <= '0;
    else if (wr_i && !sel_i) idx_q <= wdata_i;
  end

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (sec_wr),
    .step_o (sec_step)
  );

  rtc_timekeep u_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (data_wr),
    .idx_i    (idx_q),
    .wdata_i  (wdata_i),
    .step_i   (sec_step),
    .sec_wr_o (sec_wr),
    .time_o   (tm_q)
  );

  rtc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (data_rd),
    .wr_i     (data_wr),
    .idx_i    (idx_q),
    .wdata_i  (wdata_i),
    .tick_i   (tick_i),
    .uip_o    (uip),
    .per_en_o (per_en),
    .err_o    (err_o),
    .pirq_o   (pirq_o)
  );

  always_comb begin
    unique case (idx_q)
      IDX_SEC:  data_mux = tm_q.sec;
      IDX_MIN:  data_mux = tm_q.min;
      IDX_HOUR: data_mux = tm_q.hour;
      IDX_DOW:  data_mux = tm_q.dow + 8'd1;
      IDX_DOM:  data_mux = tm_q.dom;
      IDX_MON:  data_mux = tm_q.mon;
      IDX_YEAR: data_mux = tm_q.year;
      IDX_CA:   data_mux = {uip, 7'b0} | CA_RATE;
      IDX_CB:   data_mux = CB_MODE;
      default:  data_mux = 8'h00;
    endcase
  end

  assign rdata_o = sel_i ? data_mux : idx_q;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic       tick_i,
  input logic [7:0] rdata_o,
  input logic       pirq_o,
  input logic       err_o,
  input logic [7:0] idx_q,
  input logic       uip_q,
  input logic       per_en,
  input logic [7:0] min_q,
  input logic       sec_step
);
  logic rd_a, wr_b, wr_b_ok, wr_cd;
  assign rd_a    = rd_i && sel_i && (idx_q == IDX_CA);
  assign wr_b    = wr_i && sel_i && (idx_q == IDX_CB);
  assign wr_b_ok = wr_b && ((wdata_i & 8'hB7) == 8'h06);
  assign wr_cd   = wr_i && sel_i && ((idx_q == IDX_CC) || (idx_q == IDX_CD));

  AST_UIP_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a |=> (uip_q != $past(uip_q))); // R4
  AST_UIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_a |=> $stable(uip_q)); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i && sel_i)); // R5
  AST_B_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && idx_q == IDX_CB) |-> (rdata_o == 8'h46)); // R6
  AST_B_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_b_ok |=> !err_o); // R7
  AST_PER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_b_ok |=> $stable(per_en)); // R8
  AST_PIRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pirq_o |-> $past(tick_i && per_en)); // R9
  AST_CD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cd |=> err_o); // R10
  AST_MIN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(min_q) |-> $past((wr_i && sel_i) || sec_step)); // R12
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .tick_i   (tick_i),
  .rdata_o  (rdata_o),
  .pirq_o   (pirq_o),
  .err_o    (err_o),
  .idx_q    (idx_q),
  .uip_q    (uip),
  .per_en   (per_en),
  .min_q    (tm_q.min),
  .sec_step (sec_step)
);

// File: tb/sim_rtc_regfile.sv
`timescale 1ns/1ps
module sim_rtc_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0, tick = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pirq, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .tick_i(tick), .rdata_o(rdata), .pirq_o(pirq), .err_o(err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic get(input logic s, output logic [7:0] d);
    @(negedge clk); sel = s; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
    put(1'b0, idx); put(1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] idx, output logic [7:0] d);
    put(1'b0, idx); get(1'b1, d);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic uip_m;
    logic en_m;
    bit legal;
    logic [7:0] plain [6];
    plain = '{8'h00, 8'h02, 8'h04, 8'h07, 8'h08, 8'h09};

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 err", {7'b0, err}, 8'h00);
    check("R1 pirq", {7'b0, pirq}, 8'h00);
    get(1'b0, d); check("R1 index", d, 8'h00);
    foreach (plain[i]) begin rreg(plain[i], d); check("R1 time", d, 8'h00); end
    rreg(8'h06, d); check("R1 dow", d, 8'h01);
    ticks(1); check("R1 periodic enabled", {7'b0, pirq}, 8'h01);
    rreg(8'h0A, d); check("R1 regA", d, 8'h26);
    uip_m = 1'b1;

    // R4 update-in-progress alternates
    for (int k = 0; k < 6; k++) begin
      get(1'b1, d); check("R4 regA", d, {uip_m, 7'b0} | 8'h26);
      uip_m = ~uip_m;
    end

    // R2 index port and plain time registers, full byte sweep
    put(1'b0, 8'h5C); get(1'b0, d); check("R2 index readback", d, 8'h5C);
    foreach (plain[i]) begin
      put(1'b0, plain[i]);
      for (int v = 0; v < 256; v++) begin
        put(1'b1, 8'(v)); get(1'b1, d); check("R2 time reg", d, 8'(v));
      end
    end

    // R3 day of week round trip
    for (int v = 1; v <= 7; v++) begin
      wreg(8'h06, 8'(v)); rreg(8'h06, d); check("R3 dow", d, 8'(v));
    end

    // R13 unimplemented indices
    for (int ix = 1; ix < 32; ix++) begin
      if (ix == 1 || ix == 3 || ix == 5 || ix >= 14) begin
        wreg(8'(ix), 8'hA5); check("R13 no err", {7'b0, err}, 8'h00);
        get(1'b1, d); check("R13 read zero", d, 8'h00);
      end
    end

    // R10 registers C and D
    for (int ix = 12; ix <= 13; ix++) begin
      rreg(8'(ix), d); check("R10 read", d, 8'h00);
      put(1'b1, 8'h00); check("R10 write err", {7'b0, err}, 8'h01);
    end

    // R5 register A write sweep
    put(1'b0, 8'h0A);
    for (int v = 0; v < 256; v++) begin
      put(1'b1, 8'(v));
      check("R5 regA err", {7'b0, err}, (v == 8'h26) ? 8'h00 : 8'h01);
    end

    // R6 R7 R8 R9 register B write sweep
    en_m = 1'b1;
    for (int v = 0; v < 256; v++) begin
      put(1'b0, 8'h0B);
      put(1'b1, 8'(v));
      legal = ((v & 8'hB7) == 8'h06);
      check("R7 regB err", {7'b0, err}, legal ? 8'h00 : 8'h01);
      if (legal) en_m = v[6];
      get(1'b1, d); check("R6 regB read", d, 8'h46);
      ticks(1); check("R8 R9 pirq after tick", {7'b0, pirq}, {7'b0, en_m});
      @(posedge clk); #1 check("R9 pirq one cycle", {7'b0, pirq}, 8'h00);
    end

    // R11 seconds prescaler
    wreg(8'h00, 8'd10);
    ticks(1023); rreg(8'h00, d); check("R11 before boundary", d, 8'd10);
    ticks(1); get(1'b1, d); check("R11 at boundary", d, 8'd11);
    ticks(500); wreg(8'h00, 8'd20);
    ticks(1023); rreg(8'h00, d); check("R11 restart hold", d, 8'd20);
    ticks(1); get(1'b1, d); check("R11 restart step", d, 8'd21);

    // R12 carries
    wreg(8'h04, 8'd5); wreg(8'h02, 8'd7); wreg(8'h00, 8'd59);
    ticks(1024);
    rreg(8'h00, d); check("R12 sec wrap", d, 8'd0);
    rreg(8'h02, d); check("R12 min carry", d, 8'd8);
    wreg(8'h02, 8'd59); wreg(8'h00, 8'd59);
    ticks(1024);
    rreg(8'h00, d); check("R12 sec wrap 2", d, 8'd0);
    rreg(8'h02, d); check("R12 min wrap", d, 8'd0);
    rreg(8'h04, d); check("R12 hours unchanged", d, 8'd5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule